// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a two-wire SMBus target that gives a host access to a small bank of byte-wide configuration registers. Each access starts by setting a register index. A write then carries a byte count and that many data bytes. A read begins with a repeated start and a read address. The target answers with a length byte, followed by register contents taken from consecutive indices. The length byte is read from a host-writable register in the bank.

The clock and data lines are open drain. The block samples both lines through synchronizers and pulls SDA low through a single enable output. It never stretches the clock. A two-bit select pin is sampled once, in the first cycle after reset, and picks one of three 7-bit device addresses. The bank powers up with defaults, so the logic it controls works with no bus traffic at all. The enable bits for the clock outputs are combined with active-low hardware enable pins. A local port lets neighbouring logic read and write the same bank.

Top module: `smb_idx_regs`

## Requirements
- R1: After reset the bank holds these values: index 0 = 0xFF, index 1 = 0x01, index 8 = 0x08, every other index = 0x00. SDA is released.
- R2: The device address is picked from the select pin in the first cycle after reset: 0 gives 0x68, 1 gives 0x69, 2 or 3 gives 0x6A. Later changes on the pin have no effect until the next reset.
- R3: When the address byte does not match, the target does not acknowledge it and keeps SDA released for the rest of that transfer.
- R4: A write is framed as address+W, index N, count X, then data. The target acknowledges the address, the index, the count and each of the first X data bytes. Those bytes land in indices N, N+1, and so on.
- R5: Data bytes beyond the count X are not acknowledged and are not stored.
- R6: Writes to indices 9 and above are acknowledged and discarded. Reads from those indices return 0x00.
- R7: A read is framed as address+W, index N, repeated start, address+R. The target then returns the value of index 8, followed by the bytes from index N upward, for as long as the host acknowledges. A host not-acknowledge ends the transfer and leaves SDA released.
- R8: The host can write index 8, and the length byte returned by later reads follows that value.
- R9: A stop, whether between bytes or in the middle of a byte, ends the transfer. Data bytes already acknowledged stay stored, and nothing is written for an unfinished byte.
- R10: Output enable k is high only when its enable bit is set and oe_pin_n[k] is low. Enable bit k lives at index k/8, bit k%8. The output is registered, so it follows its inputs after one clock.
- R11: A local write with loc_we updates index loc_idx at the next clock edge. loc_rdata shows the value at loc_idx one clock later, and 0x00 when loc_idx is out of range.
- R12: The target starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | Pulls SDA low when high |
| addr_sel | input | 2 | Device address select, sampled once after reset |
| oe_pin_n | input | NUM_OUT | Active-low hardware output enables |
| out_en | output | NUM_OUT | Combined output enables |
| loc_we | input | 1 | Local register write strobe |
| loc_idx | input | IDXW | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data, registered |

## Verification
A protocol engine that has fallen out of step with the bus shows up on the very next acknowledge slot. The bench sees either a missing acknowledge or one in an extra slot, and it records the acknowledge pattern for every byte. A wrong auto-incremented index or length register corrupts the following bytes of a read transfer. Every byte of every read is compared against a model of the bank, so that corruption is caught within the same transfer. A stored value that went wrong without showing up on the bus appears on out_en one clock later, or at the local read port.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKWAIT, ST_ACK, ST_TX, ST_RACK, ST_RACKWAIT
  } fsm_st_t;

  typedef enum logic [1:0] {
    RL_ADDR, RL_INDEX, RL_COUNT, RL_DATA
  } role_t;

  // Power-up contents: enable registers all ones for implemented outputs,
  // length register at the top index, everything else zero.
  function automatic logic [7:0] reg_default(int idx, int nregs, int nout,
                                             logic [7:0] defcnt);
    logic [7:0] v;
    v = 8'h00;
    if (idx == nregs - 1) v = defcnt;
    else begin
      for (int b = 0; b < 8; b++)
        if (idx * 8 + b < nout) v[b] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, sda_m, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_lvl <= 1'b1; sda_lvl <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in; sda_m <= sda_in;
      scl_lvl <= scl_m; sda_lvl <= sda_m;
      scl_q <= scl_lvl; sda_q <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int NUM_REGS = 9,
  parameter int NUM_OUT = 9,
  parameter int IDXW = 8,
  parameter logic [7:0] DEF_COUNT = 8'h08
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [IDXW-1:0] bus_idx,
  input  logic [7:0]      bus_wdata,
  input  logic [IDXW-1:0] bus_ridx,
  output logic [7:0]      bus_rdata,
  output logic [7:0]      cnt_val,
  input  logic            loc_we,
  input  logic [IDXW-1:0] loc_idx,
  input  logic [7:0]      loc_wdata,
  output logic [7:0]      loc_rdata,
  output logic [NUM_OUT-1:0] en_bits
);
  import smb_pkg::*;
  localparam int CNT_IDX = NUM_REGS - 1;

  logic [NUM_REGS-1:0][7:0] regs;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs[i] <= reg_default(i, NUM_REGS, NUM_OUT, DEF_COUNT);
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (loc_we && loc_idx == IDXW'(i)) regs[i] <= loc_wdata;
        else if (bus_we && bus_idx == IDXW'(i)) regs[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (bus_ridx == IDXW'(i)) bus_rdata = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) loc_rdata <= 8'h00;
    else begin
      loc_rdata <= 8'h00;
      for (int i = 0; i < NUM_REGS; i++)
        if (loc_idx == IDXW'(i)) loc_rdata <= regs[i];
    end
  end

  assign cnt_val = regs[CNT_IDX];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_en
    assign en_bits[k] = regs[k / 8][k % 8];
  end

  // R6: an out-of-range bus write leaves the bank untouched
  assert_oor_discard_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_idx >= IDXW'(NUM_REGS) && !loc_we) |=> $stable(regs));
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_lvl,
  input  logic            sda_lvl,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic [6:0]      dev_addr,
  input  logic [7:0]      cnt_val,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            bus_we,
  output logic [IDXW-1:0] bus_idx,
  output logic [7:0]      bus_wdata,
  output logic            sda_pull
);
  import smb_pkg::*;

  fsm_st_t st;
  role_t   role;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] txreg;
  logic [IDXW-1:0] idx;
  logic [7:0] wcnt;
  logic rw;
  logic [7:0] rx_byte;

  assign rx_byte = {shreg, sda_lvl};
  assign rd_idx  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; role <= RL_ADDR; bitcnt <= 3'd0; shreg <= 7'd0;
      txreg <= 8'd0; idx <= '0; wcnt <= 8'd0; rw <= 1'b0;
      sda_pull <= 1'b0; bus_we <= 1'b0; bus_idx <= '0; bus_wdata <= 8'd0;
    end else begin
      bus_we <= 1'b0;
      if (stop_ev) begin
        st <= ST_IDLE; sda_pull <= 1'b0;
      end else if (start_ev) begin
        st <= ST_RX; role <= RL_ADDR; bitcnt <= 3'd0; sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_rise) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              case (role)
                RL_ADDR: begin
                  if (rx_byte[7:1] == dev_addr) begin
                    rw <= rx_byte[0]; st <= ST_ACKWAIT;
                  end else st <= ST_IDLE;
                end
                RL_INDEX: begin idx <= IDXW'(rx_byte); st <= ST_ACKWAIT; end
                RL_COUNT: begin wcnt <= rx_byte; st <= ST_ACKWAIT; end
                default: begin
                  if (wcnt != 8'd0) begin
                    bus_we <= 1'b1; bus_idx <= idx; bus_wdata <= rx_byte;
                    idx <= idx + IDXW'(1); wcnt <= wcnt - 8'd1;
                    st <= ST_ACKWAIT;
                  end else st <= ST_IDLE;
                end
              endcase
            end
          end
          ST_ACKWAIT: if (scl_fall) begin
            sda_pull <= 1'b1; st <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            bitcnt <= 3'd0;
            if (role == RL_ADDR && rw) begin
              txreg <= cnt_val; sda_pull <= ~cnt_val[7]; st <= ST_TX;
            end else begin
              sda_pull <= 1'b0; st <= ST_RX;
              case (role)
                RL_ADDR:  role <= RL_INDEX;
                RL_INDEX: role <= RL_COUNT;
                default:  role <= RL_DATA;
              endcase
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_pull <= 1'b0; st <= ST_RACK;
            end else begin
              txreg <= {txreg[6:0], 1'b0}; sda_pull <= ~txreg[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_RACK: if (scl_rise) st <= sda_lvl ? ST_IDLE : ST_RACKWAIT;
          ST_RACKWAIT: if (scl_fall) begin
            txreg <= rd_data; sda_pull <= ~rd_data[7];
            idx <= idx + IDXW'(1); bitcnt <= 3'd0; st <= ST_TX;
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end

  // R12: the target begins pulling SDA only while SCL is low
  assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_lvl);

  // R9: a stop always leaves SDA released on the next cycle
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_pull);
endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs #(
  parameter int NUM_OUT = 9,
  parameter int NUM_REGS = 9,
  parameter int IDXW = 8,
  parameter logic [7:0] DEF_COUNT = 8'h08,
  parameter logic [6:0] ADDR_A = 7'h68,
  parameter logic [6:0] ADDR_B = 7'h69,
  parameter logic [6:0] ADDR_C = 7'h6A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic [1:0]         addr_sel,
  input  logic [NUM_OUT-1:0] oe_pin_n,
  output logic [NUM_OUT-1:0] out_en,
  input  logic               loc_we,
  input  logic [IDXW-1:0]    loc_idx,
  input  logic [7:0]         loc_wdata,
  output logic [7:0]         loc_rdata
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic bus_we;
  logic [IDXW-1:0] bus_idx, rd_idx;
  logic [7:0] bus_wdata, rd_data, cnt_val;
  logic [NUM_OUT-1:0] en_bits;
  logic [6:0] dev_addr;
  logic sel_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_done <= 1'b0; dev_addr <= ADDR_A;
    end else if (!sel_done) begin
      sel_done <= 1'b1;
      case (addr_sel)
        2'd0:    dev_addr <= ADDR_A;
        2'd1:    dev_addr <= ADDR_B;
        default: dev_addr <= ADDR_C;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_en <= '0;
    else     out_en <= en_bits & ~oe_pin_n;
  end

  smb_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_proto_fsm #(.IDXW(IDXW)) u_fsm (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .dev_addr(dev_addr), .cnt_val(cnt_val),
    .rd_data(rd_data), .rd_idx(rd_idx), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .sda_pull(sda_pull)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .NUM_OUT(NUM_OUT), .IDXW(IDXW),
                 .DEF_COUNT(DEF_COUNT)) u_bank (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_ridx(rd_idx), .bus_rdata(rd_data),
    .cnt_val(cnt_val), .loc_we(loc_we), .loc_idx(loc_idx),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .en_bits(en_bits)
  );

  // R2: once picked, the device address never moves until reset
  assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_done && $past(sel_done)) |-> $stable(dev_addr));

  // R10: a deasserted hardware pin always forces its output enable low
  assert_pin_gates_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((out_en & $past(oe_pin_n)) == '0));
endmodule

// File: tb/test_smb_idx_regs.sv
module test_smb_idx_regs;
  localparam int Q  = 6;
  localparam int NO = 9;
  localparam int NR = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, scl_h, sda_low, loc_we, sda_pull, sda_line;
  logic [1:0] sel;
  logic [NO-1:0] pins, out_en;
  logic [7:0] loc_idx, loc_wdata, loc_rdata;
  logic [7:0] model [NR];
  int n_chk, n_fail;
  logic watch, seen_pull, r12_bad;

  assign sda_line = ~(sda_low | sda_pull);

  smb_idx_regs i_smb_idx_regs (
    .clk(clk), .rst(rst), .scl_in(scl_h), .sda_in(sda_line),
    .sda_pull(sda_pull), .addr_sel(sel), .oe_pin_n(pins), .out_en(out_en),
    .loc_we(loc_we), .loc_idx(loc_idx), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  logic pull_q;
  always @(negedge clk) begin
    pull_q <= sda_pull;
    if (watch && sda_pull) seen_pull <= 1'b1;
    if (sda_pull && !pull_q && scl_h) r12_bad <= 1'b1;
  end

  function automatic logic [7:0] dflt(int i);
    if (i == 0) return 8'hFF;
    if (i == 1) return 8'h01;
    if (i == 8) return 8'h08;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(int i);
    return (i >= 0 && i < NR) ? model[i] : 8'h00;
  endfunction

  function automatic logic [NO-1:0] exp_en();
    logic [NO-1:0] e;
    for (int k = 0; k < NO; k++) e[k] = model[k / 8][k % 8] & ~pins[k];
    return e;
  endfunction

  function automatic logic [11:0] exp_acks(int x, int nb);
    logic [11:0] a;
    a = 12'h007;
    for (int i = 0; i < nb; i++) a[3 + i] = (i < x);
    return a;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    sda_low = ~b; tick(Q); scl_h = 1'b1; tick(2 * Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_low = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); b = sda_line;
    tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic byte_out(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic byte_in(logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~ack);
  endtask

  task automatic do_start();
    sda_low = 1'b1; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic do_rstart();
    sda_low = 1'b0; tick(Q); scl_h = 1'b1; tick(Q);
    sda_low = 1'b1; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sda_low = 1'b1; tick(Q); scl_h = 1'b1; tick(Q); sda_low = 1'b0; tick(2 * Q);
  endtask

  // Block write; acks bit0 addr, bit1 index, bit2 count, bit3+i data byte i.
  task automatic wr_block(logic [6:0] a, logic [7:0] n, logic [7:0] x, int nb,
                          logic [7:0][7:0] d, int extra_bits,
                          output logic [11:0] acks);
    logic ak;
    acks = '0;
    do_start();
    byte_out({a, 1'b0}, ak); acks[0] = ak;
    byte_out(n, ak); acks[1] = ak;
    byte_out(x, ak); acks[2] = ak;
    for (int i = 0; i < nb; i++) begin
      byte_out(d[i], ak); acks[3 + i] = ak;
      if (ak && acks[0] && int'(n) + i < NR) model[int'(n) + i] = d[i];
    end
    for (int i = 0; i < extra_bits; i++) bit_out(1'b0);
    do_stop();
  endtask

  task automatic rd_block(logic [6:0] a, logic [7:0] n, int nb,
                          output logic [7:0][7:0] got);
    logic ak;
    got = '0;
    do_start();
    byte_out({a, 1'b0}, ak);
    byte_out(n, ak);
    do_rstart();
    byte_out({a, 1'b1}, ak);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] v;
      byte_in(i != nb - 1, v);
      got[i] = v;
    end
    do_stop();
  endtask

  task automatic rd_check(string req, logic [6:0] a, logic [7:0] n, int nb);
    logic [7:0][7:0] got;
    rd_block(a, n, nb, got);
    chk({req, "/R8 length byte"}, got[0], model[8]);
    for (int i = 1; i < nb; i++)
      chk({req, " data byte"}, got[i], exp_rd(int'(n) + i - 1));
  endtask

  task automatic reset_dut();
    rst = 1'b1; tick(4); rst = 1'b0; tick(3);
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] acks;
    logic [7:0][7:0] d;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    scl_h = 1'b1; sda_low = 1'b0; sel = 2'd0; pins = '0;
    loc_we = 1'b0; loc_idx = '0; loc_wdata = '0;
    watch = 1'b0; seen_pull = 1'b0; r12_bad = 1'b0;
    reset_dut();

    // R1 reset contents through the local port, plus released SDA
    for (int i = 0; i <= NR; i++) begin
      loc_idx = 8'(i); tick(2);
      chk("R1/R11 reset value", loc_rdata, exp_rd(i));
    end
    chk("R1 SDA released", sda_pull, 1'b0);
    chk("R1/R10 enables after reset", out_en, 9'h1FF);

    // R10 pin gating
    pins = 9'h0A5; tick(2);
    chk("R10 pin gating", out_en, exp_en());

    // R4 plain block write
    d = '0; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    wr_block(7'h68, 8'd2, 8'd3, 3, d, 0, acks);
    chk("R4 acks", acks, exp_acks(3, 3));
    for (int i = 2; i < 5; i++) begin
      loc_idx = 8'(i); tick(2);
      chk("R4 stored byte", loc_rdata, exp_rd(i));
    end

    // R5 byte past count
    d[0] = 8'h5C; d[1] = 8'hC5;
    wr_block(7'h68, 8'd5, 8'd1, 2, d, 0, acks);
    chk("R5 acks", acks, exp_acks(1, 2));
    loc_idx = 8'd6; tick(2);
    chk("R5 extra byte not stored", loc_rdata, 8'h00);

    // R6/R8 write across the top of the bank, then read back
    d[0] = 8'h44; d[1] = 8'h03; d[2] = 8'h99;
    wr_block(7'h68, 8'd7, 8'd3, 3, d, 0, acks);
    chk("R6 out-of-range write acked", acks, exp_acks(3, 3));
    rd_check("R6/R7", 7'h68, 8'd7, 4);
    chk("R7 SDA released after nack", sda_pull, 1'b0);
    rd_check("R7", 7'h68, 8'd0, 6);

    // R3 foreign address
    watch = 1'b1;
    wr_block(7'h6B, 8'd0, 8'd1, 1, d, 0, acks);
    watch = 1'b0;
    chk("R3 no acks", acks, 12'h000);
    chk("R3 SDA never pulled", seen_pull, 1'b0);

    // R9 stop between bytes and in the middle of a byte
    d[0] = 8'hA1; d[1] = 8'hB2;
    wr_block(7'h68, 8'd3, 8'd3, 1, d, 0, acks);
    wr_block(7'h68, 8'd4, 8'd3, 1, d, 4, acks);
    rd_check("R9", 7'h68, 8'd2, 6);

    // R11 local write visible on the bus
    loc_idx = 8'd6; loc_wdata = 8'h5A; loc_we = 1'b1; tick(1); loc_we = 1'b0;
    model[6] = 8'h5A; tick(1);
    chk("R11 local readback", loc_rdata, 8'h5A);
    rd_check("R11", 7'h68, 8'd6, 2);

    // R2 select pin ignored after latch, then a new selection via reset
    sel = 2'd2; tick(2);
    wr_block(7'h6A, 8'd0, 8'd0, 0, d, 0, acks);
    chk("R2 late select ignored", acks[0], 1'b0);
    wr_block(7'h68, 8'd0, 8'd0, 0, d, 0, acks);
    chk("R2 latched address", acks[0], 1'b1);
    sel = 2'd1; reset_dut();
    wr_block(7'h68, 8'd0, 8'd0, 0, d, 0, acks);
    chk("R2 old address rejected", acks[0], 1'b0);
    wr_block(7'h69, 8'd0, 8'd0, 0, d, 0, acks);
    chk("R2 select 1 address", acks[0], 1'b1);

    // Random traffic against the model
    for (int it = 0; it < 12; it++) begin
      int n, x, nb;
      n = int'($urandom % 12); x = 1 + int'($urandom % 4); nb = 1 + int'($urandom % 4);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      wr_block(7'h69, 8'(n), 8'(x), nb, d, 0, acks);
      chk("R4/R5 random acks", acks, exp_acks(x, nb));
      pins = 9'($urandom); tick(2);
      chk("R10 random enables", out_en, exp_en());
      rd_check("R7 random", 7'h69, 8'($urandom % 12), 1 + int'($urandom % 5));
    end

    chk("R12 SDA pulled only with SCL low", r12_bad, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule